// File: doc/BRIEF.md
# Serially Programmed Parallel Control Register

This block gives a host a small bank of parallel control outputs that it can program with only three general-purpose lines. The lines are a serial data bit, a shift clock and a load strobe. Each rising edge of the shift clock pushes the current data bit into a staging register, and the first bit sent ends up as the most significant bit. A rising edge of the load strobe then copies the whole staging word to the outputs in one step, so the outputs never show a word that is only partly shifted in.

The three host lines are asynchronous to the block's system clock. Each line passes through a two-flop synchroniser before edge detection, so all state changes happen on system-clock edges. If more bits are shifted than the register holds, only the most recent ones are kept. A load with no shifts before it writes the current staging contents to the outputs again.

Top module: `sctl_latch_reg`

## Requirements
- R1: While `rst` is high at a clock edge, both the staging register and `ctrl_o` are cleared to zero. A load issued after reset with no shifts first therefore drives `ctrl_o` to 0.
- R2: `ctrl_o` changes only in response to a rising edge on `ser_load_i`. Shifting, shift-clock activity and a load line held high all leave `ctrl_o` unchanged.
- R3: After exactly WIDTH shifts (default 4), a load drives `ctrl_o` to the shifted word. The first bit sent appears at bit WIDTH-1 and the last bit sent at bit 0.
- R4: A bit is captured only on a rising edge of `ser_clk_i`. Changes on `ser_data_i` while the shift clock is high, and falling shift-clock edges, capture nothing.
- R5: When more than WIDTH bits are shifted before a load, the load presents only the last WIDTH bits sent.
- R6: A load with no shifts since the previous load presents the staging contents again, so `ctrl_o` keeps its value.
- R7: When `ser_load_i` is first sampled high at clock edge n and stays high, `ctrl_o` takes the new value at edge n+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data_i | input | 1 | Serial data bit, asynchronous |
| ser_clk_i | input | 1 | Shift clock, rising edge captures data, asynchronous |
| ser_load_i | input | 1 | Load strobe, rising edge updates outputs, asynchronous |
| ctrl_o | output | WIDTH | Latched parallel control outputs |

## Verification
The assertions assume that each host line stays at one level for at least two system-clock cycles. They also assume that the data bit is already stable when its shift-clock edge reaches the edge detector, so a synchronised data value always belongs to a single bit period. The stimulus holds every line level for five clock cycles and changes data only while the shift clock is low. The one exception is the deliberate data toggling while the shift clock is high, which must be ignored. A cycle-by-cycle model in the bench, driven from the raw samples taken at each clock edge, tracks the synchroniser delay, so any timing difference shows up as a mismatch.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int LINE_COUNT = 3;

    typedef enum logic [1:0] {
        LINE_DATA = 2'd0,
        LINE_SCLK = 2'd1,
        LINE_LOAD = 2'd2
    } line_idx_e;

    typedef struct packed {
        logic load;
        logic sclk;
        logic data;
    } host_lines_t;

    typedef struct packed {
        logic shift_rise;
        logic load_rise;
        logic data_bit;
    } ctrl_events_t;

    function automatic logic [LINE_COUNT-1:0] pack_lines(input host_lines_t l);
        logic [LINE_COUNT-1:0] v;
        v[LINE_DATA] = l.data;
        v[LINE_SCLK] = l.sclk;
        v[LINE_LOAD] = l.load;
        return v;
    endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);
    logic [STAGES-1:0][LINES-1:0] pipe;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/sctl_edge.sv
module sctl_edge #(
    parameter int LINES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] level_i,
    output logic [LINES-1:0] rise_o
);
    logic [LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_rise
            assign rise_o[i] = level_i[i] & ~prev_q[i];
        end
    endgenerate
endmodule

// File: rtl/sctl_stage.sv
module sctl_stage #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] stage_o
);
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_d;

    always_comb begin
        stage_d = stage_q;
        if (shift_i) stage_d = {stage_q[WIDTH-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign stage_o = stage_q;
endmodule

// File: rtl/sctl_hold.sv
module sctl_hold #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] stage_i,
    output logic [WIDTH-1:0] out_o
);
    logic [WIDTH-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst)         out_q <= '0;
        else if (load_i) out_q <= stage_i;
    end

    assign out_o = out_q;
endmodule

// File: rtl/sctl_latch_reg.sv
module sctl_latch_reg #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_data_i,
    input  logic             ser_clk_i,
    input  logic             ser_load_i,
    output logic [WIDTH-1:0] ctrl_o
);
    import sctl_pkg::*;

    host_lines_t                raw_lines;
    logic [LINE_COUNT-1:0]      raw_vec;
    logic [LINE_COUNT-1:0]      sync_vec;
    logic [LINE_COUNT-1:0]      rise_vec;
    ctrl_events_t               ev;
    logic [WIDTH-1:0]           stage;

    assign raw_lines.data = ser_data_i;
    assign raw_lines.sclk = ser_clk_i;
    assign raw_lines.load = ser_load_i;
    assign raw_vec        = pack_lines(raw_lines);

    sctl_sync #(.LINES(LINE_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(raw_vec), .sync_o(sync_vec)
    );

    sctl_edge #(.LINES(LINE_COUNT)) u_edge (
        .clk(clk), .rst(rst), .level_i(sync_vec), .rise_o(rise_vec)
    );

    assign ev.data_bit   = sync_vec[LINE_DATA];
    assign ev.shift_rise = rise_vec[LINE_SCLK];
    assign ev.load_rise  = rise_vec[LINE_LOAD];

    sctl_stage #(.WIDTH(WIDTH)) u_stage (
        .clk(clk), .rst(rst), .shift_i(ev.shift_rise), .bit_i(ev.data_bit),
        .stage_o(stage)
    );

    sctl_hold #(.WIDTH(WIDTH)) u_hold (
        .clk(clk), .rst(rst), .load_i(ev.load_rise), .stage_i(stage),
        .out_o(ctrl_o)
    );
endmodule

// File: rtl/sctl_checker.sv
module sctl_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_rise,
    input logic             load_rise,
    input logic [WIDTH-1:0] stage,
    input logic [WIDTH-1:0] ctrl_o
);
    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    always @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clear_R1: assert (ctrl_o == '0 && stage == '0)
                else $error("reset did not clear state");
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load_rise |=> $stable(ctrl_o));

    assert_load_copy_R3: assert property (@(posedge clk) disable iff (rst)
        load_rise |=> (ctrl_o == $past(stage)));

    assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
        shift_rise |=> (stage[WIDTH-1:1] == $past(stage[WIDTH-2:0])));

    assert_idle_stage_R6: assert property (@(posedge clk) disable iff (rst)
        !shift_rise |=> $stable(stage));
endmodule

bind sctl_latch_reg sctl_checker #(.WIDTH(WIDTH)) u_checker (
    .clk(clk), .rst(rst), .shift_rise(ev.shift_rise), .load_rise(ev.load_rise),
    .stage(stage), .ctrl_o(ctrl_o)
);

// File: tb/tb_sctl_latch_reg.sv
module tb_sctl_latch_reg;
    localparam int PERIOD = 10;
    localparam int W      = 4;
    localparam int HOLD   = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         d = 1'b0, sc = 1'b0, ld = 1'b0;
    logic [W-1:0] ctrl_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    sctl_latch_reg dut (
        .clk(clk), .rst(rst), .ser_data_i(d), .ser_clk_i(sc),
        .ser_load_i(ld), .ctrl_o(ctrl_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // reference model: raw samples taken at each edge, newest first
    logic [2:0]   hist [$];
    logic [W-1:0] m_stage = '0;
    logic [W-1:0] m_out   = '0;

    initial begin
        for (int i = 0; i < 3; i++) hist.push_front(3'b000);
    end

    always @(posedge clk) begin
        logic [2:0] cur;
        cur = {ld, sc, d};
        if (rst) begin
            m_stage = '0;
            m_out   = '0;
            hist.delete();
            for (int i = 0; i < 3; i++) hist.push_front(3'b000);
        end else begin
            // hist[1] is what the design sees synchronised, hist[2] one edge older
            if (hist[1][2] && !hist[2][2]) m_out = m_stage;
            if (hist[1][1] && !hist[2][1]) m_stage = {m_stage[W-2:0], hist[1][0]};
            hist.push_front(cur);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (ctrl_o !== m_out) begin
                errors++;
                $display("FAIL R2 model compare: actual %h expected %h", ctrl_o, m_out);
            end
        end
    end

    task automatic check(input string req, input logic [W-1:0] exp);
        checks++;
        if (ctrl_o !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, ctrl_o, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk); d = b; wait_n(HOLD);
        sc = 1'b1; wait_n(HOLD);
        sc = 1'b0; wait_n(HOLD);
    endtask

    task automatic shift_word(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
        d = 1'b0; wait_n(HOLD);
    endtask

    task automatic pulse_load();
        @(negedge clk); ld = 1'b1; wait_n(HOLD);
        ld = 1'b0; wait_n(HOLD);
    endtask

    initial begin
        wait_n(4);
        check("R1 during reset", 4'h0);
        rst = 1'b0;
        wait_n(2);
        check("R1 after reset", 4'h0);

        // R3: MSB first
        shift_word(16'hB, 4);
        check("R2 unchanged after shifts", 4'h0);
        pulse_load();
        check("R3 word 1011", 4'hB);

        shift_word(16'h6, 4);
        check("R2 unchanged before load", 4'hB);
        pulse_load();
        check("R3 word 0110", 4'h6);

        // R6: load with no shifts
        pulse_load();
        check("R6 reload", 4'h6);

        // R5: six bits 110010 -> last four 0010
        shift_word(16'h32, 6);
        pulse_load();
        check("R5 overflow keeps last four", 4'h2);

        // R4: data toggled while clock high is ignored, falling edge ignored
        for (int i = 3; i >= 0; i--) begin
            logic b;
            b = (4'h9 >> i) & 1;
            @(negedge clk); d = b; wait_n(HOLD);
            sc = 1'b1; wait_n(HOLD);
            d = ~b; wait_n(HOLD);
            d = b; wait_n(HOLD);
            d = ~b; wait_n(HOLD);
            sc = 1'b0; wait_n(HOLD);
        end
        d = 1'b0; wait_n(HOLD);
        pulse_load();
        check("R4 rising edge capture only", 4'h9);

        // R2: load held high, shifting does not change outputs
        @(negedge clk); ld = 1'b1; wait_n(HOLD);
        check("R2 load high", 4'h9);
        shift_word(16'h5, 4);
        check("R2 shifts while load high", 4'h9);
        ld = 1'b0; wait_n(HOLD);
        check("R2 load fall", 4'h9);

        // R7: latency of the load
        @(negedge clk); ld = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R7 not yet at edge n+1", 4'h9);
        @(posedge clk);
        @(negedge clk);
        check("R7 updated at edge n+2", 4'h5);
        ld = 1'b0; wait_n(HOLD);

        // R1: reset mid-operation clears staging too
        shift_word(16'hE, 4);
        @(negedge clk); rst = 1'b1; wait_n(2);
        check("R1 reset clears outputs", 4'h0);
        rst = 1'b0; wait_n(2);
        pulse_load();
        check("R1 staging cleared", 4'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule